// File: doc/BRIEF.md
# Four Digit Adding Calculator

This block is the arithmetic and display core of a small keypad calculator. Each key press arrives as a 4-bit code with a one-cycle valid strobe. The block builds decimal operands digit by digit and keeps a running total in BCD. It drives a 16-bit display word made of four 4-bit character fields. Field `disp[15:12]` is the leftmost position and `disp[3:0]` is the rightmost. Leading zeros are shown as blanks.

When a sum no longer fits in four decimal digits, the block latches an error state. The display then shows an error character, and only the clear key is accepted until it is pressed. Keypad scanning, debouncing and segment decoding happen outside the block.

Top module: `calc4_top`

## Requirements
- R1: After reset, or one cycle after the clear key (code 12), the display reads `16'hFFF0` (three blanks, then '0') and `overflow` is low. Display codes: 0–9 are digits, 10 is 'E', 15 is blank.
- R2: A digit key (codes 0–9) shifts the current operand one decimal place left and appends the new digit. The operand is then shown right-aligned, with leading positions blank.
- R3: Once four significant digits have been entered, further digit keys are ignored. Zeros typed while the operand is still zero do not count as significant digits.
- R4: The add key (code 10) adds the operand to the running total, shows the new total and clears the operand.
- R5: The equals key (code 11) adds the pending operand and shows the final total. A digit key pressed directly after equals starts a new calculation from a total of zero.
- R6: A sum above 9999 shows `16'hFFFA` (three blanks, then 'E') and raises `overflow`.
- R7: While `overflow` is high, every key except clear leaves both the display and `overflow` unchanged.
- R8: A value of zero is shown as a single '0' in the rightmost field. Key codes 13–15 are ignored. Every display field holds only a code from 0 to 10, or 15.
- R9: The display and `overflow` change only on the clock edge that samples a valid key. They are registered, so a new value is visible one cycle after that edge, and they hold while `key_valid` is low, whatever `key_code` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | One-cycle strobe marking a key press |
| key_code | input | 4 | Key: 0–9 digits, 10 add, 11 equals, 12 clear |
| disp | output | 16 | Four display character fields, leftmost in the top nibble |
| overflow | output | 1 | Sticky error flag for a sum above 9999 |

## Verification
Every result of this block appears exactly one clock edge after the edge that samples the key: display word and error flag alike, with no multi-cycle arithmetic. The bench drives a key on a falling edge and drops the strobe on the next falling edge. The rising edge in between is the only one that sees the key, so the bench compares `disp` and `overflow` at that second falling edge. Hold checks drive a key code with the strobe low and compare several falling edges later, confirming nothing moved.

// File: rtl/calc4_pkg.sv
package calc4_pkg;
  localparam int unsigned KEY_W  = 4;
  localparam int unsigned SYM_W  = 4;

  localparam logic [KEY_W-1:0] KEY_ADD = 4'd10;
  localparam logic [KEY_W-1:0] KEY_EQ  = 4'd11;
  localparam logic [KEY_W-1:0] KEY_CLR = 4'd12;

  localparam logic [SYM_W-1:0] SYM_ERR   = 4'd10;
  localparam logic [SYM_W-1:0] SYM_BLANK = 4'd15;

  typedef enum logic [2:0] {
    KC_NONE,
    KC_DIGIT,
    KC_ADD,
    KC_EQ,
    KC_CLR
  } key_cls_t;

  typedef enum logic [1:0] {
    PH_ENTRY,
    PH_DONE,
    PH_ERROR
  } phase_t;
endpackage

// File: rtl/calc4_keydec.sv
module calc4_keydec
  import calc4_pkg::*;
(
  input  logic             valid,
  input  logic [KEY_W-1:0] code,
  output key_cls_t         cls,
  output logic [3:0]       digit
);
  always_comb begin
    cls   = KC_NONE;
    digit = code[3:0];
    if (valid) begin
      if (code <= 4'd9) begin
        cls = KC_DIGIT;
      end else begin
        case (code)
          KEY_ADD: cls = KC_ADD;
          KEY_EQ:  cls = KC_EQ;
          KEY_CLR: cls = KC_CLR;
          default: cls = KC_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/calc4_bcd_add.sv
module calc4_bcd_add #(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = 4 * DIGITS
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry
);
  logic [DIGITS:0] cy;
  assign cy[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [4:0] raw;
    logic [4:0] adj;
    assign raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'd0, cy[g]};
    assign adj = raw + 5'd6;
    assign cy[g+1] = (raw > 5'd9);
    assign sum[4*g +: 4] = cy[g+1] ? adj[3:0] : raw[3:0];
  end

  assign carry = cy[DIGITS];
endmodule

// File: rtl/calc4_disp_fmt.sv
module calc4_disp_fmt
  import calc4_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = 4 * DIGITS
) (
  input  logic [W-1:0] value,
  output logic [W-1:0] chars
);
  // lead[g] is high while every digit from the top down to position g is zero
  logic [DIGITS:0] lead;
  assign lead[DIGITS] = 1'b1;

  for (genvar g = DIGITS - 1; g >= 0; g--) begin : g_pos
    assign lead[g] = lead[g+1] && (value[4*g +: 4] == 4'd0);
    if (g == 0) begin : g_last
      assign chars[3:0] = value[3:0];
    end else begin : g_upper
      assign chars[4*g +: 4] = lead[g] ? SYM_BLANK : value[4*g +: 4];
    end
  end
endmodule

// File: rtl/calc4_top.sv
module calc4_top
  import calc4_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 key_valid,
  input  logic [KEY_W-1:0]     key_code,
  output logic [4*DIGITS-1:0]  disp,
  output logic                 overflow
);
  localparam int unsigned BCD_W = 4 * DIGITS;
  localparam int unsigned CNT_W = $clog2(DIGITS + 1);
  localparam logic [BCD_W-1:0] ZERO_DISP = {{(DIGITS-1){SYM_BLANK}}, 4'd0};
  localparam logic [BCD_W-1:0] ERR_DISP  = {{(DIGITS-1){SYM_BLANK}}, SYM_ERR};

  logic [BCD_W-1:0] acc_q, opnd_q, acc_n, opnd_n;
  logic [CNT_W-1:0] ndig_q, ndig_n;
  phase_t           phase_q, phase_n;
  logic [BCD_W-1:0] disp_q;
  logic             ovf_q;

  key_cls_t         cls;
  logic [3:0]       digit;
  logic [BCD_W-1:0] sum;
  logic             carry;
  logic [BCD_W-1:0] show_n;
  logic [BCD_W-1:0] fmt_out;
  logic             upd;

  calc4_keydec u_dec (
    .valid (key_valid),
    .code  (key_code),
    .cls   (cls),
    .digit (digit)
  );

  calc4_bcd_add #(.DIGITS(DIGITS)) u_add (
    .a     (acc_q),
    .b     (opnd_q),
    .sum   (sum),
    .carry (carry)
  );

  calc4_disp_fmt #(.DIGITS(DIGITS)) u_fmt (
    .value (show_n),
    .chars (fmt_out)
  );

  always_comb begin
    acc_n   = acc_q;
    opnd_n  = opnd_q;
    ndig_n  = ndig_q;
    phase_n = phase_q;
    show_n  = opnd_q;
    upd     = 1'b0;
    if (cls == KC_CLR) begin
      acc_n   = '0;
      opnd_n  = '0;
      ndig_n  = '0;
      phase_n = PH_ENTRY;
      show_n  = '0;
      upd     = 1'b1;
    end else if (phase_q != PH_ERROR) begin
      case (cls)
        KC_DIGIT: begin
          if (phase_q == PH_DONE) begin
            acc_n   = '0;
            opnd_n  = {{(BCD_W-4){1'b0}}, digit};
            ndig_n  = (digit != 4'd0) ? CNT_W'(1) : '0;
            phase_n = PH_ENTRY;
            show_n  = opnd_n;
            upd     = 1'b1;
          end else if (ndig_q < CNT_W'(DIGITS)) begin
            opnd_n = BCD_W'({opnd_q, digit});
            if ((opnd_q != '0) || (digit != 4'd0)) begin
              ndig_n = ndig_q + CNT_W'(1);
            end
            show_n = opnd_n;
            upd    = 1'b1;
          end
        end
        KC_ADD, KC_EQ: begin
          upd = 1'b1;
          if (carry) begin
            phase_n = PH_ERROR;
          end else begin
            acc_n   = sum;
            opnd_n  = '0;
            ndig_n  = '0;
            phase_n = (cls == KC_EQ) ? PH_DONE : PH_ENTRY;
            show_n  = sum;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      opnd_q  <= '0;
      ndig_q  <= '0;
      phase_q <= PH_ENTRY;
      disp_q  <= ZERO_DISP;
      ovf_q   <= 1'b0;
    end else begin
      acc_q   <= acc_n;
      opnd_q  <= opnd_n;
      ndig_q  <= ndig_n;
      phase_q <= phase_n;
      if (upd) begin
        disp_q <= (phase_n == PH_ERROR) ? ERR_DISP : fmt_out;
        ovf_q  <= (phase_n == PH_ERROR);
      end
    end
  end

  assign disp     = disp_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/calc4_chk.sv
module calc4_chk
  import calc4_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                key_valid,
  input logic [KEY_W-1:0]    key_code,
  input logic [4*DIGITS-1:0] disp,
  input logic                overflow
);
  localparam logic [4*DIGITS-1:0] ZERO_DISP = {{(DIGITS-1){SYM_BLANK}}, 4'd0};
  localparam logic [4*DIGITS-1:0] ERR_DISP  = {{(DIGITS-1){SYM_BLANK}}, SYM_ERR};

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      reset_state_chk: assert (disp == ZERO_DISP && !overflow);
    end
  end

  // R1
  clear_key_chk: assert property (@(posedge clk) disable iff (rst)
    (key_valid && key_code == KEY_CLR) |=> (disp == ZERO_DISP && !overflow));

  // R6
  err_display_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (disp == ERR_DISP));

  // R7
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !(key_valid && key_code == KEY_CLR)) |=> (overflow && $stable(disp)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !key_valid |=> ($stable(disp) && $stable(overflow)));

  // R8
  for (genvar g = 0; g < DIGITS; g++) begin : g_sym
    always @(posedge clk) begin
      if (rst_d === 1'b0 && !rst) begin
        legal_sym_chk: assert (disp[4*g +: 4] <= SYM_ERR || disp[4*g +: 4] == SYM_BLANK);
      end
    end
  end
endmodule

bind calc4_top calc4_chk #(.DIGITS(DIGITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .key_valid (key_valid),
  .key_code  (key_code),
  .disp      (disp),
  .overflow  (overflow)
);

// File: tb/calc4_top_bench.sv
module calc4_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_valid = 1'b0;
  logic [3:0]  key_code = 4'd0;
  logic [15:0] disp;
  logic        overflow;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  calc4_top u_calc4_top (
    .clk       (clk),
    .rst       (rst),
    .key_valid (key_valid),
    .key_code  (key_code),
    .disp      (disp),
    .overflow  (overflow)
  );

  // {requirement, key, expected display, expected overflow}
  localparam int NV = 37;
  localparam logic [24:0] VEC [NV] = '{
    {4'd2, 4'h1, 16'hFFF1, 1'b0},   // R2
    {4'd2, 4'h2, 16'hFF12, 1'b0},   // R2
    {4'd2, 4'h3, 16'hF123, 1'b0},   // R2
    {4'd2, 4'h4, 16'h1234, 1'b0},   // R2
    {4'd3, 4'h5, 16'h1234, 1'b0},   // R3 fifth digit dropped
    {4'd4, 4'hA, 16'h1234, 1'b0},   // R4
    {4'd4, 4'h9, 16'hFFF9, 1'b0},   // R4 operand cleared
    {4'd2, 4'h9, 16'hFF99, 1'b0},   // R2
    {4'd5, 4'hB, 16'h1333, 1'b0},   // R5 1234+99
    {4'd5, 4'h7, 16'hFFF7, 1'b0},   // R5 new calculation
    {4'd4, 4'hA, 16'hFFF7, 1'b0},   // R4
    {4'd8, 4'h0, 16'hFFF0, 1'b0},   // R8 zero shown once
    {4'd8, 4'h0, 16'hFFF0, 1'b0},   // R8
    {4'd2, 4'h3, 16'hFFF3, 1'b0},   // R2
    {4'd5, 4'hB, 16'hFF10, 1'b0},   // R5 7+3
    {4'd1, 4'hC, 16'hFFF0, 1'b0},   // R1
    {4'd2, 4'h9, 16'hFFF9, 1'b0},   // R2
    {4'd2, 4'h9, 16'hFF99, 1'b0},   // R2
    {4'd2, 4'h9, 16'hF999, 1'b0},   // R2
    {4'd2, 4'h9, 16'h9999, 1'b0},   // R2
    {4'd4, 4'hA, 16'h9999, 1'b0},   // R4
    {4'd2, 4'h1, 16'hFFF1, 1'b0},   // R2
    {4'd6, 4'hB, 16'hFFFA, 1'b1},   // R6 9999+1
    {4'd7, 4'h5, 16'hFFFA, 1'b1},   // R7
    {4'd7, 4'hA, 16'hFFFA, 1'b1},   // R7
    {4'd7, 4'hB, 16'hFFFA, 1'b1},   // R7
    {4'd1, 4'hC, 16'hFFF0, 1'b0},   // R1 clear leaves error
    {4'd8, 4'hD, 16'hFFF0, 1'b0},   // R8 unused code
    {4'd3, 4'h0, 16'hFFF0, 1'b0},   // R3 leading zero not counted
    {4'd3, 4'h0, 16'hFFF0, 1'b0},   // R3
    {4'd3, 4'h1, 16'hFFF1, 1'b0},   // R3
    {4'd3, 4'h2, 16'hFF12, 1'b0},   // R3
    {4'd3, 4'h3, 16'hF123, 1'b0},   // R3
    {4'd3, 4'h4, 16'h1234, 1'b0},   // R3
    {4'd3, 4'h5, 16'h1234, 1'b0},   // R3
    {4'd5, 4'hB, 16'h1234, 1'b0},   // R5
    {4'd5, 4'hB, 16'h1234, 1'b0}    // R5 repeated equals
  };

  task automatic check(input int req, input logic [15:0] exp_d, input logic exp_o);
    n_chk++;
    if (disp !== exp_d || overflow !== exp_o) begin
      n_fail++;
      $display("FAIL R%0d: disp=%h overflow=%b, expected disp=%h overflow=%b",
               req, disp, overflow, exp_d, exp_o);
    end
  endtask

  task automatic press(input logic [3:0] k);
    @(negedge clk);
    key_valid = 1'b1;
    key_code  = k;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1, 16'hFFF0, 1'b0);   // R1 reset state

    for (int i = 0; i < NV; i++) begin
      press(VEC[i][20:17]);
      check(int'(VEC[i][24:21]), VEC[i][16:1], VEC[i][0]);
    end

    // R9: key code toggles with strobe low, display holds
    press(4'h7);
    check(5, 16'hFFF7, 1'b0);
    key_code = 4'h3;
    repeat (4) @(negedge clk);
    check(9, 16'hFFF7, 1'b0);
    key_code = 4'hC;
    repeat (2) @(negedge clk);
    check(9, 16'hFFF7, 1'b0);

    // R6: overflow reached through the add key, then R7 hold
    press(4'hC);
    for (int i = 0; i < 4; i++) press(4'h9);
    press(4'hA);
    press(4'h9);
    press(4'hA);
    check(6, 16'hFFFA, 1'b1);
    press(4'h3);
    check(7, 16'hFFFA, 1'b1);
    repeat (3) @(negedge clk);
    check(7, 16'hFFFA, 1'b1);

    // R1: reset in the middle of entry
    press(4'hC);
    press(4'h5);
    press(4'h6);
    check(2, 16'hFF56, 1'b0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1, 16'hFFF0, 1'b0);
    press(4'h8);
    check(2, 16'hFFF8, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule